// File: doc/BRIEF.md
# Double-Scan Keypad Matrix Scanner

This block watches a keypad made of up to four driven scan rows and five input columns with pull-downs, 20 keys in all. While nothing is pressed it does no scanning. The rows rest at standby levels, and any column that reads high starts a scan. A scan drives each row high on its own for a fixed slot and samples the columns at the end of that slot. Two complete scans are taken and compared. When they match and some key is down, the pattern is latched into a 20-bit key vector and an active-low request flag goes low. When they differ while a key is still down, a new pair of scans starts.

The key vector leaves the block on a valid/ready interface. `key_valid` rises together with the request and stays high until the reader drives `key_ready` in the same cycle. `key_data` does not change while `key_valid` is high. No timeout applies, so back-pressure can last as long as the reader needs. When a transfer completes, the request clears and a fresh scan starts at once. The block keeps scanning and reporting until every key is released. Sleep row levels, the loan of rows 1 and 2 to segment duty, and the chip-enable line that masks the request flag all come in as plain control inputs.

Top module: `keypad_dscan`

## Requirements
- R1: After reset and with no key down, no scan runs. `row_out` holds its standby level, which is all ones when `sleep_code` is 00, and `req_n` stays high. After a scan pair that ends with all keys up, the block returns to this state.
- R2: Standby row levels depend on `sleep_code` (bit i of `row_out` is row i+1): 01 drives only row 4 high, 10 drives rows 3 and 4, and 00 or 11 drives all four. A key on a low standby row starts nothing. Reading the key vector does not change `sleep_code` handling.
- R3: `osc_wake` is high in the cycle that a column first reads high while idle, before the first scan cycle drives a row. It is low when idle with no key down.
- R4: A scan drives one row at a time, starting with row 1. Each row is driven for 48 clocks, so a full scan takes 192 clocks. After two scans the rows return to standby until the decision.
- R5: When the two scans agree and at least one key is set, `req_n` goes low and `key_valid` goes high 420 clocks after the first scan cycle. That is 421 clock edges after the edge that saw the press or the read.
- R6: When the two scans disagree and the second one still has a key set, the scan pair repeats, and the request comes 840 clocks after the first scan cycle. A press released before its second sample is never reported.
- R7: Key bit index (row-1)*5 + (col-1) of `key_data` is set for a key pressed at that row and column. Bit 0 is row 1, column 1.
- R8: While `seg_share` is high, `row_out[1:0]` stays low and `key_data[9:0]` reads 0.
- R9: `key_valid` and `key_data` hold until `key_ready` is high. A transfer drops `key_valid` on the next edge and starts a new scan pair, which reports again at 421 edges if the key is still held.
- R10: `req_n` is high whenever `ce_high` is high and during reset. `key_valid` is not affected by `ce_high`.
- R11: Reset clears `key_data` to 0 and returns the scanner to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_code | input | 2 | Sleep standby selector, 00 = normal |
| seg_share | input | 1 | Rows 1 and 2 given to segment duty |
| ce_high | input | 1 | Serial chip-enable active; masks request |
| key_in | input | 5 | Column inputs, pulled down externally |
| row_out | output | 4 | Scan row drive |
| osc_wake | output | 1 | Clock-run request from the scanner |
| req_n | output | 1 | Active-low read request |
| key_valid | output | 1 | Key vector valid |
| key_ready | input | 1 | Reader accepts key vector |
| key_data | output | 20 | Confirmed key vector |

## Verification
Row-drive faults appear on `row_out` within one cycle of the faulty slot, because the bench models the matrix from those levels. A wrong slot length shifts the edge at which the rows change at 48/49 and 192/193. A wrong window counter or a wrong agree/retry decision appears as a request edge other than 421 or 841, or as a request that never comes or comes when it should not. A wrong capture index or a missing segment mask appears as a wrong `key_data` as soon as `key_valid` rises.

// File: rtl/keypad_dscan_pkg.sv
package keypad_dscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } kst_e;
endpackage

// File: rtl/keypad_dscan_seq.sv
module keypad_dscan_seq
  import keypad_dscan_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int SLOT   = 48,
  parameter int WINDOW = 420,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_hit,
  input  logic          key_ready,
  input  logic          agree,
  input  logic          last_any,
  output kst_e          st,
  output logic          scanning,
  output logic          sample_en,
  output logic          pass,
  output logic [RW-1:0] row_idx,
  output logic          start,
  output logic          accept
);
  localparam int CW = $clog2(WINDOW);
  localparam int SW = $clog2(SLOT);
  localparam int SCAN_TOTAL = 2 * ROWS * SLOT;

  logic [CW-1:0] cnt;
  logic [SW-1:0] slot_cnt;
  logic          decide, retry;

  always_comb begin
    scanning  = (st == ST_SCAN) && (cnt < CW'(SCAN_TOTAL));
    sample_en = scanning && (slot_cnt == SW'(SLOT - 1));
    decide    = (st == ST_SCAN) && (cnt == CW'(WINDOW - 1));
    accept    = decide && agree && last_any;
    retry     = decide && !agree && last_any;
    start     = ((st == ST_IDLE) && key_hit) || ((st == ST_HOLD) && key_ready) || retry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      slot_cnt <= '0;
      row_idx  <= '0;
      pass     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (key_hit) st <= ST_SCAN;
        ST_SCAN: if (decide) st <= accept ? ST_HOLD : (retry ? ST_SCAN : ST_IDLE);
        ST_HOLD: if (key_ready) st <= ST_SCAN;
        default: st <= ST_IDLE;
      endcase
      if (start) begin
        cnt      <= '0;
        slot_cnt <= '0;
        row_idx  <= '0;
        pass     <= 1'b0;
      end else begin
        if (st == ST_SCAN) cnt <= cnt + 1'b1;
        if (scanning) begin
          if (slot_cnt == SW'(SLOT - 1)) begin
            slot_cnt <= '0;
            if (row_idx == RW'(ROWS - 1)) begin
              row_idx <= '0;
              pass    <= 1'b1;
            end else begin
              row_idx <= row_idx + 1'b1;
            end
          end else begin
            slot_cnt <= slot_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keypad_dscan_capture.sv
module keypad_dscan_capture #(
  parameter int ROWS     = 4,
  parameter int COLS     = 5,
  parameter int SEG_ROWS = 2,
  localparam int RW   = $clog2(ROWS),
  localparam int KEYS = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sample_en,
  input  logic            pass,
  input  logic [RW-1:0]   row_idx,
  input  logic [COLS-1:0] key_in,
  input  logic            seg_share,
  input  logic            accept,
  output logic            agree,
  output logic            last_any,
  output logic [KEYS-1:0] key_data
);
  logic [COLS-1:0] buf_a [ROWS];
  logic [COLS-1:0] buf_b [ROWS];
  logic [KEYS-1:0] a_flat, b_flat;
  logic [COLS-1:0] col_val;

  // Rows lent to segment duty never contribute key bits.
  assign col_val = (seg_share && (row_idx < RW'(SEG_ROWS))) ? '0 : key_in;

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign a_flat[r*COLS +: COLS] = buf_a[r];
    assign b_flat[r*COLS +: COLS] = buf_b[r];
  end

  assign agree    = (a_flat == b_flat);
  assign last_any = |b_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        buf_a[r] <= '0;
        buf_b[r] <= '0;
      end
      key_data <= '0;
    end else begin
      if (start) begin
        for (int r = 0; r < ROWS; r++) begin
          buf_a[r] <= '0;
          buf_b[r] <= '0;
        end
      end else if (sample_en) begin
        if (pass) buf_b[row_idx] <= col_val;
        else      buf_a[row_idx] <= col_val;
      end
      if (accept) key_data <= b_flat;
    end
  end
endmodule

// File: rtl/keypad_dscan_rowdrv.sv
module keypad_dscan_rowdrv #(
  parameter int ROWS     = 4,
  parameter int SEG_ROWS = 2,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            scanning,
  input  logic [RW-1:0]   row_idx,
  input  logic [1:0]      sleep_code,
  input  logic            seg_share,
  output logic [ROWS-1:0] row_out
);
  logic [ROWS-1:0] standby, drive, keep;

  always_comb begin
    unique case (sleep_code)
      2'b01:   standby = ROWS'(1) << (ROWS - 1);
      2'b10:   standby = ROWS'(3) << (ROWS - 2);
      default: standby = '1;
    endcase
    drive   = scanning ? (ROWS'(1) << row_idx) : standby;
    keep    = seg_share ? ~ROWS'((1 << SEG_ROWS) - 1) : '1;
    row_out = drive & keep;
  end
endmodule

// File: rtl/keypad_dscan.sv
module keypad_dscan
  import keypad_dscan_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 5,
  parameter int SLOT     = 48,
  parameter int WINDOW   = 420,
  parameter int SEG_ROWS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sleep_code,
  input  logic                 seg_share,
  input  logic                 ce_high,
  input  logic [COLS-1:0]      key_in,
  output logic [ROWS-1:0]      row_out,
  output logic                 osc_wake,
  output logic                 req_n,
  output logic                 key_valid,
  input  logic                 key_ready,
  output logic [ROWS*COLS-1:0] key_data
);
  localparam int RW = $clog2(ROWS);

  kst_e          st;
  logic          scanning, sample_en, pass, start, accept, agree, last_any;
  logic [RW-1:0] row_idx;
  logic          key_hit;

  assign key_hit = |key_in;

  keypad_dscan_seq #(.ROWS(ROWS), .SLOT(SLOT), .WINDOW(WINDOW)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_hit(key_hit), .key_ready(key_ready),
    .agree(agree), .last_any(last_any), .st(st), .scanning(scanning),
    .sample_en(sample_en), .pass(pass), .row_idx(row_idx),
    .start(start), .accept(accept)
  );

  keypad_dscan_capture #(.ROWS(ROWS), .COLS(COLS), .SEG_ROWS(SEG_ROWS)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en),
    .pass(pass), .row_idx(row_idx), .key_in(key_in), .seg_share(seg_share),
    .accept(accept), .agree(agree), .last_any(last_any), .key_data(key_data)
  );

  keypad_dscan_rowdrv #(.ROWS(ROWS), .SEG_ROWS(SEG_ROWS)) u_row (
    .scanning(scanning), .row_idx(row_idx), .sleep_code(sleep_code),
    .seg_share(seg_share), .row_out(row_out)
  );

  assign key_valid = (st == ST_HOLD);
  assign req_n     = !key_valid || ce_high;
  assign osc_wake  = (st != ST_IDLE) || key_hit;
endmodule

// File: rtl/keypad_dscan_chk.sv
module keypad_dscan_chk
  import keypad_dscan_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 5,
  parameter int SEG_ROWS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           sleep_code,
  input logic                 seg_share,
  input logic                 ce_high,
  input logic [ROWS-1:0]      row_out,
  input logic                 osc_wake,
  input logic                 req_n,
  input logic                 key_valid,
  input logic                 key_ready,
  input logic [ROWS*COLS-1:0] key_data,
  input kst_e                 st
);
  p_req_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_high |-> req_n);

  p_req_tracks_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_high |-> (req_n == !key_valid));

  p_seg_rows_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_share |-> (row_out[SEG_ROWS-1:0] == '0));

  p_valid_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_data)));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> !key_valid);

  p_wake_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && $past(st) == ST_IDLE) |-> $past(osc_wake));

  p_sleep_top_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && sleep_code == 2'b01) |-> (row_out[ROWS-1] && $countones(row_out) == 1));
endmodule

bind keypad_dscan keypad_dscan_chk #(.ROWS(ROWS), .COLS(COLS), .SEG_ROWS(SEG_ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_code(sleep_code), .seg_share(seg_share),
  .ce_high(ce_high), .row_out(row_out), .osc_wake(osc_wake), .req_n(req_n),
  .key_valid(key_valid), .key_ready(key_ready), .key_data(key_data), .st(st)
);

// File: tb/keypad_dscan_bench.sv
module keypad_dscan_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAT  = 421;  // edges from press/read edge to request
  localparam int LAT2 = 841;  // with one retry

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sleep_code = 2'b00;
  logic        seg_share = 1'b0;
  logic        ce_high = 1'b0;
  logic [4:0]  key_in;
  logic [3:0]  row_out;
  logic        osc_wake, req_n, key_valid;
  logic        key_ready = 1'b0;
  logic [19:0] key_data;

  logic [19:0] pressed = '0;
  logic [3:0]  rows_seen [0:999];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Keypad matrix model: a column is high when a pressed key sits on a driven row.
  always_comb begin
    for (int c = 0; c < 5; c++) begin
      key_in[c] = 1'b0;
      for (int r = 0; r < 4; r++)
        if (row_out[r] && pressed[r*5 + c]) key_in[c] = 1'b1;
    end
  end

  keypad_dscan u_keypad_dscan (
    .clk(clk), .rst_n(rst_n), .sleep_code(sleep_code), .seg_share(seg_share),
    .ce_high(ce_high), .key_in(key_in), .row_out(row_out), .osc_wake(osc_wake),
    .req_n(req_n), .key_valid(key_valid), .key_ready(key_ready), .key_data(key_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(input int k0, input int maxk, input int add_k, input logic [19:0] add_m,
                          input int rel_k, input logic [19:0] rel_m, output int lat);
    lat = -1;
    for (int k = k0; k <= maxk; k++) begin
      @(negedge clk);
      rows_seen[k] = row_out;
      if (!req_n) begin
        lat = k;
        break;
      end
      if (k == add_k) pressed = pressed | add_m;
      if (k == rel_k) pressed = pressed & ~rel_m;
    end
  endtask

  task automatic ack();
    key_ready = 1'b1;
    @(negedge clk);
    key_ready = 1'b0;
    check("R9 transfer drops valid", 32'(key_valid), 32'd0);
  endtask

  task automatic t_reset();
    int lat;
    rst_n = 1'b0;
    cyc(3);
    check("R11 reset key_data", 32'(key_data), 32'd0);
    check("R11 reset valid", 32'(key_valid), 32'd0);
    check("R10 reset req_n", 32'(req_n), 32'd1);
    rst_n = 1'b1;
    cyc(2);
    check("R1 idle rows", 32'(row_out), 32'hf);
    check("R3 idle wake low", 32'(osc_wake), 32'd0);
    wait_req(1, 200, -1, '0, -1, '0, lat);
    check("R1 no request idle", 32'(lat), 32'hffffffff);
    check("R1 rows still standby", 32'(row_out), 32'hf);
  endtask

  task automatic t_single();
    int lat;
    logic [19:0] held;
    pressed = 20'(1) << 7;
    wait_req(1, 999, -1, '0, -1, '0, lat);
    check("R5 request latency", 32'(lat), 32'(LAT));
    check("R4 row1 first", 32'(rows_seen[1]), 32'h1);
    check("R4 row1 last", 32'(rows_seen[48]), 32'h1);
    check("R4 row2 start", 32'(rows_seen[49]), 32'h2);
    check("R4 row4 end", 32'(rows_seen[192]), 32'h8);
    check("R4 second scan row1", 32'(rows_seen[193]), 32'h1);
    check("R4 gap standby", 32'(rows_seen[390]), 32'hf);
    check("R7 key index row2 col3", 32'(key_data), 32'h80);
    held = key_data;
    cyc(30);
    check("R9 valid held", 32'(key_valid), 32'd1);
    check("R9 data held", 32'(key_data), 32'(held));
    ce_high = 1'b1;
    #1;
    check("R10 ce masks req", 32'(req_n), 32'd1);
    check("R10 valid kept under ce", 32'(key_valid), 32'd1);
    ce_high = 1'b0;
    #1;
    check("R10 req returns", 32'(req_n), 32'd0);
    cyc(1);
    ack();
    wait_req(2, 999, -1, '0, -1, '0, lat);
    check("R9 repeat report", 32'(lat), 32'(LAT));
    check("R9 repeat data", 32'(key_data), 32'h80);
    pressed = '0;
    ack();
    wait_req(2, 900, -1, '0, -1, '0, lat);
    check("R1 release ends scanning", 32'(lat), 32'hffffffff);
    check("R1 rows back to standby", 32'(row_out), 32'hf);
  endtask

  task automatic t_retry();
    int lat;
    pressed = 20'(1) << 10;
    wait_req(1, 999, 100, 20'h1, -1, '0, lat);
    check("R6 retry latency", 32'(lat), 32'(LAT2));
    check("R6 retry data", 32'(key_data), 32'h401);
    pressed = '0;
    ack();
    wait_req(2, 900, -1, '0, -1, '0, lat);
    check("R6 idle after retry", 32'(lat), 32'hffffffff);
  endtask

  task automatic t_short();
    int lat;
    pressed = 20'(1) << 19;
    wait_req(1, 999, -1, '0, 300, 20'(1) << 19, lat);
    check("R6 short press unreported", 32'(lat), 32'hffffffff);
    check("R6 short press no valid", 32'(key_valid), 32'd0);
    check("R1 short press back to standby", 32'(row_out), 32'hf);
  endtask

  task automatic t_sleep();
    int lat;
    sleep_code = 2'b01;
    #1;
    check("R2 code01 rows", 32'(row_out), 32'h8);
    cyc(1);
    pressed = 20'h1;
    cyc(60);
    check("R2 low row key ignored", 32'(row_out), 32'h8);
    check("R2 low row no wake", 32'(osc_wake), 32'd0);
    pressed = '0;
    cyc(1);
    pressed = 20'(1) << 15;
    #1;
    check("R3 wake on press", 32'(osc_wake), 32'd1);
    check("R3 wake before scan", 32'(row_out), 32'h8);
    wait_req(1, 999, -1, '0, -1, '0, lat);
    check("R5 sleep latency", 32'(lat), 32'(LAT));
    check("R7 key index row4 col1", 32'(key_data), 32'h8000);
    pressed = '0;
    ack();
    wait_req(2, 900, -1, '0, -1, '0, lat);
    check("R2 sleep kept after read", 32'(row_out), 32'h8);
    sleep_code = 2'b10;
    #1;
    check("R2 code10 rows", 32'(row_out), 32'hc);
    sleep_code = 2'b11;
    #1;
    check("R2 code11 rows", 32'(row_out), 32'hf);
    sleep_code = 2'b00;
    cyc(1);
  endtask

  task automatic t_seg();
    int lat;
    seg_share = 1'b1;
    #1;
    check("R8 idle rows masked", 32'(row_out), 32'hc);
    cyc(1);
    pressed = 20'h1 | (20'(1) << 11);
    wait_req(1, 999, -1, '0, -1, '0, lat);
    check("R8 latency", 32'(lat), 32'(LAT));
    check("R8 row1 slot undriven", 32'(rows_seen[5]), 32'h0);
    check("R8 low bits zero", 32'(key_data), 32'h800);
    pressed = '0;
    ack();
    wait_req(2, 900, -1, '0, -1, '0, lat);
    seg_share = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset_mid();
    int lat;
    pressed = 20'(1) << 3;
    wait_req(1, 999, -1, '0, -1, '0, lat);
    check("R5 latency before reset", 32'(lat), 32'(LAT));
    rst_n = 1'b0;
    #1;
    check("R11 reset clears data", 32'(key_data), 32'd0);
    check("R11 reset clears valid", 32'(key_valid), 32'd0);
    check("R10 reset forces req high", 32'(req_n), 32'd1);
    pressed = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
    check("R11 idle after reset", 32'(row_out), 32'hf);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_retry();
    t_short();
    t_sleep();
    t_seg();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule